// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Engine

The engine moves transmit data from memory to a byte stream. Software places descriptors in a ring in memory. Each descriptor is two 32-bit words: a control word, then an address word. Software programs the ring base and a stop index through a four-register file, then sets the enable bit. Starting at the current slot, the engine fetches descriptors one at a time. For each one it reads the buffer a word at a time and sends the bytes out in little-endian order on a ready/valid stream. The stream marks frame start and frame end. The engine keeps going until its current slot equals the stop index, and it waits there until software moves the stop index.

A single sequencer drives the work through named states:
- `S_OFF` (disabled).
- `S_DECIDE`, which checks at each descriptor boundary for suspend or the stop index.
- `S_IDLE` (idle-wait) and `S_SUSP` (suspended).
- `S_CREQ`/`S_CWAIT`, which fetch the control word.
- `S_AREQ`/`S_AWAIT`, which fetch the address word.
- `S_BREQ`/`S_BWAIT`, which read a buffer word.
- `S_EMIT`, which sends bytes.
- `S_DONE`, which retires a descriptor.
- `S_STOP`, the halt on error.

The transitions are:
- OFF→DECIDE once enabled.
- DECIDE→SUSP, →IDLE or →CREQ.
- IDLE→SUSP, or IDLE→CREQ when the stop index moves.
- SUSP→DECIDE when suspend clears.
- CREQ→CWAIT→AREQ→AWAIT, then →BREQ, →DONE (flush or a zero count) or →STOP.
- BREQ→BWAIT→EMIT or →STOP.
- EMIT→BREQ at a word boundary, or →DONE after the last byte.
- DONE→DECIDE.
- Any state→OFF when enable clears.

The memory port takes a one-cycle request with an address. It answers some cycles later with one response that carries data and an error flag. Only one request is outstanding at a time.

Top module: `txring_dma`

## Requirements
- R1: After reset, and in the cycle after software clears enable (control bit 0), the status word reads 0. That means disabled state (code 0), pointer 0 and error 0. While the engine fetches or emits, the status state field reads 1 (active).
- R2: The register offsets are 0x0 control, 0x4 ring base, 0x8 stop index (bits 11:0) and 0xC status (read-only). Control holds enable (bit 0), suspend (bit 1), loopback (bit 2), flush (bit 4) and a two-bit address extension (bits 17:16), and reads back as written.
- R3: Descriptor slot p is fetched as two word reads, the control word at D and the address word at D+4. D is the ring base with the control extension ORed into bits 31:30, plus 8·p.
- R4: A descriptor control word gives a byte count in bits 12:0 and a buffer extension in bits 17:16. The buffer address is the extension in bits 31:30 over address-word bits 29:0 (word aligned). Exactly that many buffer bytes are emitted, lowest byte of each word first.
- R5: The first byte of a descriptor carries the start marker when control bit 31 is set. Its last byte carries the end marker when bit 30 is set. Data and markers hold while the sink is not ready.
- R6: A completed descriptor advances the pointer by one, or to 0 when control bit 28 (table end) is set.
- R7: When the pointer equals the stop index, the engine enters idle-wait (state 2) and makes no memory requests. It resumes once software writes a different stop index.
- R8: Suspend (control bit 1) takes effect only at a descriptor boundary. A descriptor in progress completes first. The state then reads 4 with no further progress, and clearing suspend resumes the walk.
- R9: In loopback mode the buffer is still read, but no byte appears on the stream. Bytes are consumed at one per cycle regardless of ready.
- R10: In flush mode, descriptors are retired without any buffer read and without stream output.
- R11: A faulty response makes the engine halt in state 3 with a latched error code and a one-cycle pulse on `irq_err`. The code is 4 for a descriptor read, 3 for a buffer read, and 1 for a nonzero routing field (address-word bits 31:30). The engine then issues no request until it is disabled.
- R12: `irq_done` pulses for one cycle when a descriptor with control bit 29 retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory response word |
| mem_rerr | input | 1 | Memory response carries a fault |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | Byte is the first of a frame |
| tx_eof | output | 1 | Byte is the last of a frame |
| irq_done | output | 1 | Descriptor-complete interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |

## Verification
The assertions rely on three assumptions about the inputs:
- Memory returns exactly one response per request, and never while no request is outstanding.
- Loopback does not change while a byte is being offered.
- Software does not re-enable the engine while a response from before the disable is still in flight.

The bench memory model answers each captured request once, after a fixed latency. The bench changes mode bits only while the engine sits idle, suspended or stopped, or while the sink holds ready low with loopback unchanged.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int PTR_W   = 12;
    localparam int CNT_W   = 13;
    localparam int ERR_W   = 4;
    localparam int STC_W   = 4;
    localparam int EXT_W   = 2;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int LANE_W  = $clog2(LANES);
    localparam int SLOT_SH = 3;

    // register offsets
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_BASE = 4'h4;
    localparam logic [3:0] OFS_STOP = 4'h8;
    localparam logic [3:0] OFS_STAT = 4'hC;

    // status state codes
    localparam logic [STC_W-1:0] STC_OFF  = 4'd0;
    localparam logic [STC_W-1:0] STC_ACT  = 4'd1;
    localparam logic [STC_W-1:0] STC_IDLE = 4'd2;
    localparam logic [STC_W-1:0] STC_STOP = 4'd3;
    localparam logic [STC_W-1:0] STC_SUSP = 4'd4;

    // error codes
    localparam logic [ERR_W-1:0] ERC_NONE = 4'd0;
    localparam logic [ERR_W-1:0] ERC_PROT = 4'd1;
    localparam logic [ERR_W-1:0] ERC_BUF  = 4'd3;
    localparam logic [ERR_W-1:0] ERC_DESC = 4'd4;

    typedef enum logic [3:0] {
        S_OFF, S_DECIDE, S_IDLE, S_SUSP,
        S_CREQ, S_CWAIT, S_AREQ, S_AWAIT,
        S_BREQ, S_BWAIT, S_EMIT, S_DONE, S_STOP
    } seq_state_e;

    typedef struct packed {
        logic             sof;
        logic             eof;
        logic             irq;
        logic             wrap;
        logic [EXT_W-1:0] ext;
        logic [CNT_W-1:0] cnt;
    } desc_ctl_t;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
    import txr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] status,
    output logic [WORD_W-1:0] rdata,
    output logic              ctl_en,
    output logic              ctl_susp,
    output logic              ctl_loop,
    output logic              ctl_flush,
    output logic [EXT_W-1:0]  ctl_ext,
    output logic [WORD_W-1:0] ring_base,
    output logic [PTR_W-1:0]  stop_idx
);
    logic [WORD_W-1:0] ctrl_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en    <= 1'b0;
            ctl_susp  <= 1'b0;
            ctl_loop  <= 1'b0;
            ctl_flush <= 1'b0;
            ctl_ext   <= '0;
            ring_base <= '0;
            stop_idx  <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFS_CTRL: begin
                    ctl_en    <= wdata[0];
                    ctl_susp  <= wdata[1];
                    ctl_loop  <= wdata[2];
                    ctl_flush <= wdata[4];
                    ctl_ext   <= wdata[17:16];
                end
                OFS_BASE: ring_base <= wdata;
                OFS_STOP: stop_idx  <= wdata[PTR_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        ctrl_word        = '0;
        ctrl_word[0]     = ctl_en;
        ctrl_word[1]     = ctl_susp;
        ctrl_word[2]     = ctl_loop;
        ctrl_word[4]     = ctl_flush;
        ctrl_word[17:16] = ctl_ext;
        unique case (addr)
            OFS_CTRL: rdata = ctrl_word;
            OFS_BASE: rdata = ring_base;
            OFS_STOP: rdata = {{(WORD_W-PTR_W){1'b0}}, stop_idx};
            OFS_STAT: rdata = status;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/txr_lane.sv
module txr_lane #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    output logic [BYTE_W-1:0] byte_out
);
    logic [BYTE_W-1:0] lane_bytes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word[g*BYTE_W +: BYTE_W];
    end

    assign byte_out = lane_bytes[lane];
endmodule

// File: rtl/txr_seq.sv
module txr_seq
    import txr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              ctl_susp,
    input  logic              ctl_loop,
    input  logic              ctl_flush,
    input  logic [EXT_W-1:0]  ctl_ext,
    input  logic [WORD_W-1:0] ring_base,
    input  logic [PTR_W-1:0]  stop_idx,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rerr,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_sof,
    output logic              tx_eof,
    output logic [WORD_W-1:0] emit_word,
    output logic [LANE_W-1:0] emit_lane,
    output logic              irq_done,
    output logic              irq_err,
    output logic [STC_W-1:0]  st_code,
    output logic [ERR_W-1:0]  err_code,
    output logic [PTR_W-1:0]  cur_ptr
);
    seq_state_e        state_q, state_d;
    desc_ctl_t         dctl_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [ERR_W-1:0]  err_q;
    logic [WORD_W-1:0] buf_addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [WORD_W-1:0] word_q;
    logic [LANE_W-1:0] lane_q;
    logic              first_q;
    logic              err_pulse_q;
    logic [WORD_W-1:0] desc_addr;
    logic              take;
    logic              last_byte;
    logic [EXT_W-1:0]  route;

    assign desc_addr = {ring_base[WORD_W-1 -: EXT_W] | ctl_ext, ring_base[WORD_W-EXT_W-1:0]}
                     + {{(WORD_W-PTR_W-SLOT_SH){1'b0}}, ptr_q, {SLOT_SH{1'b0}}};
    assign take      = ctl_loop || tx_ready;
    assign last_byte = (remain_q == CNT_W'(1));
    assign route     = mem_rdata[WORD_W-1 -: EXT_W];

    // next state
    always_comb begin
        state_d = state_q;
        if (!ctl_en) begin
            state_d = S_OFF;
        end else begin
            unique case (state_q)
                S_OFF:    state_d = S_DECIDE;
                S_DECIDE: begin
                    if (ctl_susp)               state_d = S_SUSP;
                    else if (ptr_q == stop_idx) state_d = S_IDLE;
                    else                        state_d = S_CREQ;
                end
                S_IDLE: begin
                    if (ctl_susp)               state_d = S_SUSP;
                    else if (ptr_q != stop_idx) state_d = S_CREQ;
                end
                S_SUSP:   if (!ctl_susp) state_d = S_DECIDE;
                S_CREQ:   state_d = S_CWAIT;
                S_CWAIT:  if (mem_rvalid) state_d = mem_rerr ? S_STOP : S_AREQ;
                S_AREQ:   state_d = S_AWAIT;
                S_AWAIT: begin
                    if (mem_rvalid) begin
                        if (mem_rerr || route != '0)               state_d = S_STOP;
                        else if (ctl_flush || dctl_q.cnt == '0)    state_d = S_DONE;
                        else                                       state_d = S_BREQ;
                    end
                end
                S_BREQ:   state_d = S_BWAIT;
                S_BWAIT:  if (mem_rvalid) state_d = mem_rerr ? S_STOP : S_EMIT;
                S_EMIT: begin
                    if (take) begin
                        if (last_byte)                          state_d = S_DONE;
                        else if (lane_q == LANE_W'(LANES - 1))  state_d = S_BREQ;
                    end
                end
                S_DONE:   state_d = S_DECIDE;
                S_STOP:   state_d = S_STOP;
                default:  state_d = S_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_OFF;
            err_pulse_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            err_pulse_q <= (state_d == S_STOP) && (state_q != S_STOP);
        end
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dctl_q     <= '0;
            ptr_q      <= '0;
            err_q      <= ERC_NONE;
            buf_addr_q <= '0;
            remain_q   <= '0;
            word_q     <= '0;
            lane_q     <= '0;
            first_q    <= 1'b0;
        end else if (!ctl_en) begin
            ptr_q <= '0;
            err_q <= ERC_NONE;
        end else begin
            unique case (state_q)
                S_CWAIT: begin
                    if (mem_rvalid) begin
                        if (mem_rerr) begin
                            err_q <= ERC_DESC;
                        end else begin
                            dctl_q.sof  <= mem_rdata[31];
                            dctl_q.eof  <= mem_rdata[30];
                            dctl_q.irq  <= mem_rdata[29];
                            dctl_q.wrap <= mem_rdata[28];
                            dctl_q.ext  <= mem_rdata[17:16];
                            dctl_q.cnt  <= mem_rdata[CNT_W-1:0];
                        end
                    end
                end
                S_AWAIT: begin
                    if (mem_rvalid) begin
                        if (mem_rerr) begin
                            err_q <= ERC_DESC;
                        end else if (route != '0) begin
                            err_q <= ERC_PROT;
                        end else begin
                            buf_addr_q <= {dctl_q.ext, mem_rdata[WORD_W-EXT_W-1:0]};
                            remain_q   <= dctl_q.cnt;
                            lane_q     <= '0;
                            first_q    <= 1'b1;
                        end
                    end
                end
                S_BWAIT: begin
                    if (mem_rvalid) begin
                        if (mem_rerr) err_q  <= ERC_BUF;
                        else          word_q <= mem_rdata;
                    end
                end
                S_EMIT: begin
                    if (take) begin
                        remain_q <= remain_q - CNT_W'(1);
                        lane_q   <= lane_q + LANE_W'(1);
                        first_q  <= 1'b0;
                        if (lane_q == LANE_W'(LANES - 1))
                            buf_addr_q <= buf_addr_q + WORD_W'(LANES);
                    end
                end
                S_DONE: ptr_q <= dctl_q.wrap ? '0 : ptr_q + PTR_W'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        tx_valid = 1'b0;
        st_code  = STC_ACT;
        unique case (state_q)
            S_CREQ: begin mem_req = 1'b1; mem_addr = desc_addr; end
            S_AREQ: begin mem_req = 1'b1; mem_addr = desc_addr + WORD_W'(LANES); end
            S_BREQ: begin mem_req = 1'b1; mem_addr = buf_addr_q; end
            S_EMIT: tx_valid = !ctl_loop;
            S_OFF:  st_code = STC_OFF;
            S_IDLE: st_code = STC_IDLE;
            S_SUSP: st_code = STC_SUSP;
            S_STOP: st_code = STC_STOP;
            default: ;
        endcase
        tx_sof    = tx_valid && first_q && dctl_q.sof;
        tx_eof    = tx_valid && last_byte && dctl_q.eof;
        emit_word = word_q;
        emit_lane = lane_q;
        irq_done  = (state_q == S_DONE) && dctl_q.irq;
        irq_err   = err_pulse_q;
        err_code  = err_q;
        cur_ptr   = ptr_q;
    end
endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    input  logic        mem_rerr,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_sof,
    output logic        tx_eof,
    output logic        irq_done,
    output logic        irq_err
);
    logic              ctl_en, ctl_susp, ctl_loop, ctl_flush;
    logic [EXT_W-1:0]  ctl_ext;
    logic [WORD_W-1:0] ring_base;
    logic [PTR_W-1:0]  stop_idx;
    logic [STC_W-1:0]  st_code;
    logic [ERR_W-1:0]  err_code;
    logic [PTR_W-1:0]  cur_ptr;
    logic [WORD_W-1:0] status_w;
    logic [WORD_W-1:0] emit_word;
    logic [LANE_W-1:0] emit_lane;

    assign status_w = {{(WORD_W-ERR_W-STC_W-PTR_W){1'b0}}, err_code, st_code, cur_ptr};

    txr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .status(status_w), .rdata(reg_rdata),
        .ctl_en(ctl_en), .ctl_susp(ctl_susp), .ctl_loop(ctl_loop),
        .ctl_flush(ctl_flush), .ctl_ext(ctl_ext), .ring_base(ring_base),
        .stop_idx(stop_idx)
    );

    txr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_susp(ctl_susp),
        .ctl_loop(ctl_loop), .ctl_flush(ctl_flush), .ctl_ext(ctl_ext),
        .ring_base(ring_base), .stop_idx(stop_idx),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .emit_word(emit_word), .emit_lane(emit_lane),
        .irq_done(irq_done), .irq_err(irq_err),
        .st_code(st_code), .err_code(err_code), .cur_ptr(cur_ptr)
    );

    txr_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_lane (
        .word(emit_word), .lane(emit_lane), .byte_out(tx_data)
    );
endmodule

// File: rtl/txr_checker.sv
module txr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_sof,
    input logic        tx_eof,
    input logic        irq_done,
    input logic        irq_err,
    input logic        ctl_en,
    input logic [11:0] stop_idx,
    input logic [31:0] status
);
    // R1: a cleared enable leaves disabled state, pointer 0, no error
    assert_disable_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> status[19:0] == 20'h0);

    // R3: requests are single-cycle
    assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R5: an offered byte is held until accepted
    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (!ctl_en ||
            (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof))));

    // R7: idle-wait only where the pointer has reached the stop index
    assert_idle_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[15:12] == 4'd2 && $stable(stop_idx)) |-> status[11:0] == stop_idx);

    // R7: no requests while idle-waiting
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status[15:12] == 4'd2 |-> !mem_req);

    // R11: stopped engine is silent
    assert_stopped_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        status[15:12] == 4'd3 |-> (!mem_req && !tx_valid));

    // R11: error interrupt is a single pulse
    assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |=> !irq_err);

    // R12: completion interrupt is a single pulse
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);
endmodule

bind txring_dma txr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
    .irq_done(irq_done), .irq_err(irq_err), .ctl_en(ctl_en),
    .stop_idx(stop_idx), .status(status_w)
);

// File: tb/sim_txring_dma.sv
module sim_txring_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic        mem_rerr = 1'b0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_sof, tx_eof, irq_done, irq_err;

    always #2 clk = ~clk;  // 250 MHz

    txring_dma u0 (.*);

    int nchk = 0, nerr = 0, cyc = 0;
    int lat = 1, pend = 0, nreq = 0, nbuf = 0, nvalid = 0;
    int n_irq = 0, n_err_irq = 0, exp_irq = 0;
    int ng = 0, ne = 0, nchecked = 0;
    bit hold_ready = 1'b0, cap_en = 1'b0;
    logic [31:0] req_a = 0, err_addr = 32'hFFFF_FFFF, cap_addr = 0;
    logic [31:0] desc_mem [16];
    logic [7:0]  got_d [512];
    logic        got_s [512], got_e [512];
    logic [7:0]  exp_d [512];
    logic        exp_s [512], exp_e [512];

    function automatic logic [7:0] pat(input logic [31:0] b);
        logic [7:0] t;
        t = b[7:0] * 8'd7 + 8'd3;
        return t;
    endfunction

    function automatic logic [31:0] dctl_of(input int k);
        logic [31:0] c;
        c = 32'(k + 1);
        c[31] = (k != 3);
        c[30] = (k != 2);
        c[29] = (k % 2 == 1);
        c[28] = (k == 7);
        return c;
    endfunction

    function automatic logic [31:0] dbuf_of(input int k);
        return 32'h400 + 32'(k) * 32'h40;
    endfunction

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        logic [29:0] o;
        o = a[29:0];
        if (o >= 30'h100 && o < 30'h140) return desc_mem[(o - 30'h100) >> 2];
        return {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
    endfunction

    // memory model
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        mem_rerr   = 1'b0;
        if (pend != 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd_word(req_a);
                mem_rerr   = (req_a == err_addr);
            end
        end
        if (mem_req) begin
            req_a = mem_addr;
            pend  = lat;
            nreq++;
            if (mem_addr[29:0] >= 30'h400) nbuf++;
            if (cap_en) begin cap_addr = mem_addr; cap_en = 1'b0; end
        end
    end

    // stream sink and interrupt counters
    always @(negedge clk) begin
        cyc++;
        tx_ready = !hold_ready && (cyc % 3 != 0);
        if (tx_valid) nvalid++;
        if (tx_valid && tx_ready && ng < 512) begin
            got_d[ng] = tx_data; got_s[ng] = tx_sof; got_e[ng] = tx_eof; ng++;
        end
        if (irq_done) n_irq++;
        if (irq_err) n_err_irq++;
        if (cyc > 150000) begin
            nchk++; nerr++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_state(input logic [3:0] code, input string tag);
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(4'hC, s);
            if (s[15:12] == code) return;
        end
        check(1'b0, tag, s, {16'h0, code, 12'h0});
    endtask

    task automatic add_exp(input int k);
        for (int i = 0; i < k + 1; i++) begin
            exp_d[ne] = pat(dbuf_of(k) + 32'(i));
            exp_s[ne] = (i == 0) && dctl_of(k)[31];
            exp_e[ne] = (i == k) && dctl_of(k)[30];
            ne++;
        end
        if (k % 2 == 1) exp_irq++;
    endtask

    task automatic check_stream(input string tag);
        check(ng == ne, {tag, " byte count R4"}, 32'(ng), 32'(ne));
        for (int i = nchecked; i < ne && i < ng; i++)
            check(got_d[i] == exp_d[i] && got_s[i] == exp_s[i] && got_e[i] == exp_e[i],
                  {tag, " byte/marker R4 R5"}, {22'h0, got_s[i], got_e[i], got_d[i]},
                  {22'h0, exp_s[i], exp_e[i], exp_d[i]});
        nchecked = ne;
        check(n_irq == exp_irq, {tag, " irq_done count R12"}, 32'(n_irq), 32'(exp_irq));
    endtask

    initial begin
        logic [31:0] s;
        int snap, snap2;
        for (int k = 0; k < 8; k++) begin
            desc_mem[2*k]   = dctl_of(k);
            desc_mem[2*k+1] = dbuf_of(k);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'hC, s); check(s == 0, "reset status R1", s, 0);
        rd(4'h0, s); check(s == 0, "reset control R1", s, 0);
        check(!tx_valid && !mem_req, "reset outputs R1", {30'h0, tx_valid, mem_req}, 0);

        // R2 register readback
        wr(4'h0, 32'h0003_0016); rd(4'h0, s); check(s == 32'h0003_0016, "control readback R2", s, 32'h0003_0016);
        rd(4'hC, s); check(s == 0, "still disabled R2", s, 0);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h100); rd(4'h4, s); check(s == 32'h100, "base readback R2", s, 32'h100);
        wr(4'h8, 32'h5); rd(4'h8, s); check(s == 32'h5, "stop readback R2", s, 32'h5);

        // R4 R5 R6 R7 R12: walk slots 0..4, then wrap 5,6,7,0,1
        wr(4'h0, 32'h1);
        wait_state(4'd2, "run1 idle R7");
        rd(4'hC, s); check(s == 32'h0000_2005, "run1 status R7", s, 32'h0000_2005);
        for (int k = 0; k < 5; k++) add_exp(k);
        check_stream("run1");
        lat = 2;
        wr(4'h8, 32'h2);
        wait_state(4'd2, "run2 idle R7");
        rd(4'hC, s); check(s == 32'h0000_2002, "run2 wrap pointer R6", s, 32'h0000_2002);
        for (int k = 5; k < 8; k++) add_exp(k);
        add_exp(0); add_exp(1);
        check_stream("run2");
        lat = 1;

        // R8 suspend mid-descriptor
        hold_ready = 1'b1;
        wr(4'h8, 32'h4);
        for (int i = 0; i < 200 && !tx_valid; i++) @(negedge clk);
        rd(4'hC, s); check(s[15:12] == 4'd1, "active state R1", s, 32'h1000);
        wr(4'h0, 32'h3);
        hold_ready = 1'b0;
        wait_state(4'd4, "suspend R8");
        rd(4'hC, s); check(s == 32'h0000_4003, "suspend after slot R8", s, 32'h0000_4003);
        add_exp(2); check_stream("susp");
        wr(4'h0, 32'h1);
        wait_state(4'd2, "resume R8");
        rd(4'hC, s); check(s == 32'h0000_2004, "resume pointer R8", s, 32'h0000_2004);
        add_exp(3); check_stream("resume");

        // R8 suspend while idle, stop index moved
        wr(4'h0, 32'h3);
        wait_state(4'd4, "idle suspend R8");
        snap = nreq;
        wr(4'h8, 32'h6);
        repeat (20) @(negedge clk);
        rd(4'hC, s); check(s == 32'h0000_4004 && nreq == snap, "no progress suspended R8", s, 32'h0000_4004);
        wr(4'h0, 32'h1);
        wait_state(4'd2, "resume2 R8");
        add_exp(4); add_exp(5); check_stream("resume2");

        // R9 loopback: ready held low, no bytes offered
        hold_ready = 1'b1; snap = nvalid; snap2 = ng;
        wr(4'h0, 32'h5);
        wr(4'h8, 32'h0);
        wait_state(4'd2, "loopback idle R9");
        rd(4'hC, s); check(s == 32'h0000_2000, "loopback pointer R9", s, 32'h0000_2000);
        check(nvalid == snap && ng == snap2, "loopback no output R9", 32'(nvalid - snap), 0);
        exp_irq++;  // slot 7
        hold_ready = 1'b0;

        // R10 flush
        snap = nbuf; snap2 = ng;
        wr(4'h0, 32'h11);
        wr(4'h8, 32'h3);
        wait_state(4'd2, "flush idle R10");
        rd(4'hC, s); check(s == 32'h0000_2003, "flush pointer R10", s, 32'h0000_2003);
        check(nbuf == snap && ng == snap2, "flush no buffer read R10", 32'(nbuf - snap), 0);
        exp_irq++;  // slot 1
        check(n_irq == exp_irq, "irq after modes R12", 32'(n_irq), 32'(exp_irq));

        // R1 disable clears pointer
        wr(4'h0, 32'h0);
        rd(4'hC, s); check(s == 0, "disable clears R1", s, 0);

        // R3 control extension on descriptor fetch
        wr(4'h8, 32'h1);
        cap_en = 1'b1;
        wr(4'h0, 32'h0001_0001);
        wait_state(4'd2, "ext idle R3");
        check(cap_addr == 32'h4000_0100, "fetch address extension R3", cap_addr, 32'h4000_0100);
        add_exp(0); check_stream("ext");
        wr(4'h0, 32'h0);

        // R11 descriptor fault
        snap = n_err_irq; err_addr = 32'h100;
        wr(4'h0, 32'h1);
        wait_state(4'd3, "desc fault R11");
        rd(4'hC, s); check(s == 32'h0004_3000, "desc fault status R11", s, 32'h0004_3000);
        snap2 = nreq; repeat (10) @(negedge clk);
        check(nreq == snap2 && n_err_irq == snap + 1, "halt quiet, one pulse R11", 32'(n_err_irq - snap), 1);
        wr(4'h0, 32'h0);
        rd(4'hC, s); check(s == 0, "disable clears error R1", s, 0);

        // R11 buffer fault
        err_addr = 32'h400;
        wr(4'h0, 32'h1);
        wait_state(4'd3, "buf fault R11");
        rd(4'hC, s); check(s == 32'h0003_3000, "buffer fault status R11", s, 32'h0003_3000);
        wr(4'h0, 32'h0);

        // R11 nonzero routing
        err_addr = 32'hFFFF_FFFF;
        desc_mem[1] = 32'h4000_0400;
        wr(4'h0, 32'h1);
        wait_state(4'd3, "route fault R11");
        rd(4'hC, s); check(s == 32'h0001_3000, "routing fault status R11", s, 32'h0001_3000);
        check(n_err_irq == snap + 3, "error pulses R11", 32'(n_err_irq - snap), 3);
        wr(4'h0, 32'h0);
        desc_mem[1] = dbuf_of(0);
        check(ng == ne, "no stray bytes R4", 32'(ng), 32'(ne));

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule